// File: doc/BRIEF.md
# Six-Pulse Thyristor Gate Sequencer

This block drives the six gate lines of a three-phase thyristor bridge. A line-tracking loop elsewhere supplies a predicted crossing time, the locked period and one sixth of that period, all expressed on a free-running 16-bit timer that the whole chip shares. The sequencer keeps its own firing reference. On start it copies the crossing time into that reference, and then advances it by one period on every line cycle. Six times per cycle it raises a fixed pair of gates, and a programmable number of ticks later it drops all of them.

The firing delay is a signed tick count held in a saturating register. An outer controller steps it up or down by fixed amounts. It is added at the point where each firing instant is computed, outside the tracking loop, so a change applies in full at the next firing instant. Pulses are produced only while the sequencer is running and the loop reports lock. A stop request or a loss of lock ends the run, and a new start request is then needed.

Top module: `thyr_gate_seq`

## Requirements
- R1: After reset all six gate outputs are low, `firing_o` is low and the delay register holds zero.
- R2: A start request is accepted only while `lock_i` is high. On acceptance, `firing_o` rises and the firing reference is loaded with `zc_i`. A start request while unlocked leaves `firing_o` low.
- R3: Step k (k = 0..5) fires when the timer reaches reference + k·`sixth_i` + delay. The gate pairs, with gate n on bit n-1 of `gates_o`, are in order: k0 gates 1 and 6 (6'b100001), k1 gates 1 and 2 (6'b000011), k2 gates 3 and 2 (6'b000110), k3 gates 3 and 4 (6'b001100), k4 gates 5 and 4 (6'b011000), k5 gates 5 and 6 (6'b110000).
- R4: All gates return low when the timer reaches the step's firing time plus `PULSE_W`.
- R5: After step 5 ends, the reference grows by `period_i` and the sequence restarts at k0.
- R6: Within one clock of `lock_i` low or `stop_i` high, `firing_o` and all gates are low. They stay low, even if lock returns, until a new start.
- R7: A one-clock `dly_inc_i` (`dly_dec_i`) adds (subtracts) `DLY_STEP` ticks to the delay, clamped to [`DLY_MIN`, `DLY_MAX`]. The new value governs the next firing instant, including one within a run already in progress.
- R8: A negative delay fires before the reference instant by its magnitude.
- R9: An event counts as reached when the timer minus the event time, taken as a signed 16-bit value, is non-negative, so schedules that span the timer's wrap stay correct.
- R10: At any time either no gate or exactly two gates are high, and a high pattern is held until it drops to all-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_i | input | 16 | Shared free-running timer |
| zc_i | input | 16 | Predicted line crossing time from the tracking loop |
| period_i | input | 16 | Locked line period in ticks |
| sixth_i | input | 16 | One sixth of the locked period in ticks |
| lock_i | input | 1 | Tracking loop reports lock |
| start_i | input | 1 | Start request pulse |
| stop_i | input | 1 | Stop request pulse |
| dly_inc_i | input | 1 | Raise delay by one step |
| dly_dec_i | input | 1 | Lower delay by one step |
| gates_o | output | 6 | Gate drive lines, gate n on bit n-1 |
| firing_o | output | 1 | Run indicator |

## Verification
A firing instant can be reached in the very clock where lock is withdrawn. When that happens, the shutdown must win and no pair may rise. The bench arranges this by dropping `lock_i` in the same clock that the timer reaches the first scheduled firing time. It then judges the outcome by requiring that no gate pattern appears and that the run indicator is low afterwards. A delay step landing during a live run is also provoked between two firing steps, and the later step's timing is judged against the new delay.

// File: rtl/thyr_seq_pkg.sv
package thyr_seq_pkg;

  localparam int NGATE = 6;
  localparam int NSTEP = 6;
  localparam int KW    = $clog2(NSTEP);

  typedef enum logic {
    PH_ARM  = 1'b0,
    PH_HOLD = 1'b1
  } seq_phase_t;

  // gate pair driven on each sixth of the cycle; gate n sits on bit n-1
  function automatic logic [NGATE-1:0] step_pair(input logic [KW-1:0] k);
    logic [NGATE-1:0] p;
    case (k)
      3'd0:    p = 6'b100001;
      3'd1:    p = 6'b000011;
      3'd2:    p = 6'b000110;
      3'd3:    p = 6'b001100;
      3'd4:    p = 6'b011000;
      default: p = 6'b110000;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/seq_delay_reg.sv
module seq_delay_reg #(
  parameter int TW       = 16,
  parameter int DLY_STEP = 250,
  parameter int DLY_MIN  = -1000,
  parameter int DLY_MAX  = 1100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inc,
  input  logic                 dec,
  output logic signed [TW-1:0] dly
);

  localparam int XW = TW + 2;
  localparam logic signed [XW-1:0] STEP_X = XW'(DLY_STEP);
  localparam logic signed [XW-1:0] MIN_X  = XW'(DLY_MIN);
  localparam logic signed [XW-1:0] MAX_X  = XW'(DLY_MAX);

  logic signed [XW-1:0] cur_x;
  logic signed [XW-1:0] sum_x;
  logic signed [XW-1:0] clamp_x;

  always_comb begin
    cur_x = {{2{dly[TW-1]}}, dly};
    if (inc && !dec)      sum_x = cur_x + STEP_X;
    else if (dec && !inc) sum_x = cur_x - STEP_X;
    else                  sum_x = cur_x;
    if (sum_x > MAX_X)      clamp_x = MAX_X;
    else if (sum_x < MIN_X) clamp_x = MIN_X;
    else                    clamp_x = sum_x;
  end

  always_ff @(posedge clk) begin
    if (rst) dly <= '0;
    else     dly <= clamp_x[TW-1:0];
  end

endmodule

// File: rtl/seq_due.sv
module seq_due #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] now,
  input  logic [TW-1:0] evt,
  output logic          due
);

  logic [TW-1:0] gap;

  always_comb begin
    gap = now - evt;
    due = ~gap[TW-1];
  end

endmodule

// File: rtl/thyr_gate_seq.sv
module thyr_gate_seq
  import thyr_seq_pkg::*;
#(
  parameter int TW       = 16,
  parameter int PULSE_W  = 100,
  parameter int DLY_STEP = 250,
  parameter int DLY_MIN  = -1000,
  parameter int DLY_MAX  = 1100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    timer_i,
  input  logic [TW-1:0]    zc_i,
  input  logic [TW-1:0]    period_i,
  input  logic [TW-1:0]    sixth_i,
  input  logic             lock_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             dly_inc_i,
  input  logic             dly_dec_i,
  output logic [NGATE-1:0] gates_o,
  output logic             firing_o
);

  localparam logic [KW-1:0] K_LAST = KW'(NSTEP - 1);
  localparam logic [TW-1:0] WIDTH  = TW'(PULSE_W);

  logic signed [TW-1:0] dly_q;
  logic [TW-1:0]        fref_q;
  logic [TW-1:0]        base_q;
  logic [TW-1:0]        low_q;
  logic [KW-1:0]        k_q;
  seq_phase_t           ph_q;
  logic [TW-1:0]        fire_t;
  logic                 fire_due;
  logic                 low_due;

  seq_delay_reg #(
    .TW(TW), .DLY_STEP(DLY_STEP), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)
  ) u_dly (
    .clk(clk), .rst(rst), .inc(dly_inc_i), .dec(dly_dec_i), .dly(dly_q)
  );

  // delay added live so a new command applies at the very next instant
  assign fire_t = base_q + $unsigned(dly_q);

  seq_due #(.TW(TW)) u_due_fire (.now(timer_i), .evt(fire_t), .due(fire_due));
  seq_due #(.TW(TW)) u_due_low  (.now(timer_i), .evt(low_q),  .due(low_due));

  always_ff @(posedge clk) begin
    if (rst) begin
      firing_o <= 1'b0;
      gates_o  <= '0;
      fref_q   <= '0;
      base_q   <= '0;
      low_q    <= '0;
      k_q      <= '0;
      ph_q     <= PH_ARM;
    end else if (stop_i || !lock_i) begin
      firing_o <= 1'b0;
      gates_o  <= '0;
      ph_q     <= PH_ARM;
    end else if (!firing_o) begin
      if (start_i) begin
        firing_o <= 1'b1;
        fref_q   <= zc_i;
        base_q   <= zc_i;
        k_q      <= '0;
        ph_q     <= PH_ARM;
        gates_o  <= '0;
      end
    end else begin
      case (ph_q)
        PH_ARM: begin
          if (fire_due) begin
            gates_o <= step_pair(k_q);
            low_q   <= fire_t + WIDTH;
            ph_q    <= PH_HOLD;
          end
        end
        default: begin
          if (low_due) begin
            gates_o <= '0;
            ph_q    <= PH_ARM;
            if (k_q == K_LAST) begin
              k_q    <= '0;
              fref_q <= fref_q + period_i;
              base_q <= fref_q + period_i;
            end else begin
              k_q    <= k_q + 1'b1;
              base_q <= base_q + sixth_i;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/thyr_gate_seq_chk.sv
module thyr_gate_seq_chk #(
  parameter int TW       = 16,
  parameter int DLY_STEP = 250,
  parameter int DLY_MIN  = -1000,
  parameter int DLY_MAX  = 1100
) (
  input logic                 clk,
  input logic                 rst,
  input logic [5:0]           gates,
  input logic                 firing,
  input logic                 lock,
  input logic                 stop,
  input logic [TW-1:0]        zc,
  input logic                 inc,
  input logic                 dec,
  input logic signed [TW-1:0] dly,
  input logic [TW-1:0]        fref
);

  localparam logic signed [TW-1:0] STEPV = TW'(DLY_STEP);
  localparam logic signed [TW-1:0] MINV  = TW'(DLY_MIN);
  localparam logic signed [TW-1:0] MAXV  = TW'(DLY_MAX);

  a_r10_two_or_none: assert property (@(posedge clk) disable iff (rst)
    (gates == 6'd0) || ($countones(gates) == 2));

  a_r10_pattern_held: assert property (@(posedge clk) disable iff (rst)
    (gates != 6'd0) |=> ((gates == $past(gates)) || (gates == 6'd0)));

  a_r6_idle_dark: assert property (@(posedge clk) disable iff (rst)
    !firing |-> (gates == 6'd0));

  a_r6_shutdown: assert property (@(posedge clk) disable iff (rst)
    (!lock || stop) |=> (!firing && (gates == 6'd0)));

  a_r2_start_loads_ref: assert property (@(posedge clk) disable iff (rst)
    $rose(firing) |-> ((fref == $past(zc)) && $past(lock)));

  a_r7_dly_in_range: assert property (@(posedge clk) disable iff (rst)
    (dly >= MINV) && (dly <= MAXV));

  a_r7_dly_up: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |=> ((dly == $past(dly) + STEPV) || (dly == MAXV)));

  a_r7_dly_down: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |=> ((dly == $past(dly) - STEPV) || (dly == MINV)));

endmodule

bind thyr_gate_seq thyr_gate_seq_chk #(
  .TW(TW), .DLY_STEP(DLY_STEP), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)
) u_chk (
  .clk(clk), .rst(rst), .gates(gates_o), .firing(firing_o), .lock(lock_i),
  .stop(stop_i), .zc(zc_i), .inc(dly_inc_i), .dec(dly_dec_i),
  .dly(dly_q), .fref(fref_q)
);

// File: tb/thyr_gate_seq_tb.sv
module thyr_gate_seq_tb_top;

  localparam int P6 = 600;
  localparam int PP = 3600;
  localparam int PW = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timer;
  logic [15:0] zc = '0;
  logic [15:0] period = 16'(PP);
  logic [15:0] sixth = 16'(P6);
  logic        lock = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        inc = 1'b0;
  logic        dec = 1'b0;
  logic [5:0]  gates;
  logic        firing;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] rise_t [0:15];
  logic [5:0]  rise_g [0:15];
  logic [15:0] fall_t [0:15];
  int nr = 0;
  int nf = 0;

  thyr_gate_seq dut_i (
    .clk(clk), .rst(rst), .timer_i(timer), .zc_i(zc), .period_i(period),
    .sixth_i(sixth), .lock_i(lock), .start_i(start), .stop_i(stop),
    .dly_inc_i(inc), .dly_dec_i(dec), .gates_o(gates), .firing_o(firing)
  );

  always #5 clk = ~clk;

  // timer advances 5 ns after every rising edge
  initial begin
    timer = 16'h0100;
    forever begin
      @(posedge clk);
      #5;
      timer <= timer + 16'd1;
    end
  end

  // gate edge log, sampled 2 ns after each rising edge
  initial begin
    logic [5:0] prev;
    prev = '0;
    forever begin
      @(posedge clk);
      #2;
      if (gates != prev && gates != 6'd0) begin
        if (nr < 16) begin rise_t[nr] = timer; rise_g[nr] = gates; end
        nr++;
      end
      if (gates == 6'd0 && prev != 6'd0) begin
        if (nf < 16) fall_t[nf] = timer;
        nf++;
      end
      prev = gates;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_pair(input int k);
    case (k % 6)
      0: return 6'b100001;
      1: return 6'b000011;
      2: return 6'b000110;
      3: return 6'b001100;
      4: return 6'b011000;
      default: return 6'b110000;
    endcase
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_stop();
    @(posedge clk); #5 stop = 1'b1;
    @(posedge clk); #5 stop = 1'b0;
  endtask

  task automatic step_dly(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if (up) inc = 1'b1; else dec = 1'b1;
      @(posedge clk); #5;
      inc = 1'b0; dec = 1'b0;
    end
  endtask

  task automatic start_at(input int offset);
    @(posedge clk); #4;
    zc = timer + 16'(offset);
    nr = 0; nf = 0;
    #1 start = 1'b1;
    @(posedge clk); #5 start = 1'b0;
  endtask

  task automatic wait_rises(input int n, input string req);
    int t;
    t = 0;
    while (nr < n && t < 12000) begin @(posedge clk); t++; end
    check(nr >= n, req, nr, n);
  endtask

  task automatic check_run(input int n, input int dly, input string req);
    for (int k = 0; k < n; k++) begin
      logic [15:0] e;
      e = zc + 16'((k % 6) * P6 + (k / 6) * PP + dly);
      check(rise_t[k] == e, req, int'(rise_t[k]), int'(e));
      check(rise_g[k] == exp_pair(k), "R3 pair", int'(rise_g[k]), int'(exp_pair(k)));
      check(fall_t[k] == e + 16'(PW), "R4 width", int'(fall_t[k]), int'(e + 16'(PW)));
    end
  endtask

  task automatic t_reset();
    cycles(3);
    #2;
    check(gates == 6'd0, "R1 gates", int'(gates), 0);
    check(firing == 1'b0, "R1 firing", int'(firing), 0);
    rst = 1'b0;
  endtask

  task automatic t_start_unlocked();
    lock = 1'b0;
    start_at(50);
    cycles(400);
    #2;
    check(firing == 1'b0, "R2 start needs lock", int'(firing), 0);
    check(nr == 0, "R2 no pulses unlocked", nr, 0);
  endtask

  task automatic t_wrap_run();
    lock = 1'b1;
    @(posedge clk); #3 timer = 16'hFB00;
    start_at(50);
    wait_rises(7, "R5 seven steps");
    cycles(PW + 5);
    check(firing == 1'b1, "R2 running", int'(firing), 1);
    // steps 0..2 before wrap, 3..6 after: R9 plus R3 R5
    check_run(7, 0, "R3 R5 R9 firing time");
  endtask

  task automatic t_delay_live();
    pulse_stop();
    start_at(50);
    wait_rises(1, "R7 first step");
    step_dly(1, 1'b1);
    wait_rises(2, "R7 second step");
    check(rise_t[1] == zc + 16'(P6 + 250), "R7 live delay", int'(rise_t[1]), int'(zc + 16'(P6 + 250)));
  endtask

  task automatic t_delay_sat();
    pulse_stop();
    step_dly(4, 1'b1);
    start_at(50);
    wait_rises(2, "R7 max run");
    check(rise_t[0] == zc + 16'(1100), "R7 max clamp", int'(rise_t[0]), int'(zc + 16'(1100)));
    pulse_stop();
    step_dly(10, 1'b0);
    start_at(1200);
    wait_rises(2, "R8 run");
    check(rise_t[0] == zc - 16'd1000, "R8 R7 min clamp early fire", int'(rise_t[0]), int'(zc - 16'd1000));
    check(rise_t[1] == zc + 16'(P6 - 1000), "R8 second step", int'(rise_t[1]), int'(zc + 16'(P6 - 1000)));
  endtask

  task automatic t_lock_loss();
    int seen;
    do begin @(posedge clk); #2; end while (gates == 6'd0);
    #3 lock = 1'b0;
    @(posedge clk); #2;
    check(gates == 6'd0, "R6 lock loss gates", int'(gates), 0);
    check(firing == 1'b0, "R6 lock loss firing", int'(firing), 0);
    #3 lock = 1'b1;
    seen = nr;
    cycles(4000);
    #2;
    check(nr == seen, "R6 no restart on relock", nr, seen);
    check(firing == 1'b0, "R6 stays stopped", int'(firing), 0);
  endtask

  task automatic t_stop();
    start_at(1200);
    wait_rises(1, "R6 stop run");
    pulse_stop();
    #2;
    check(firing == 1'b0, "R6 stop firing", int'(firing), 0);
    check(gates == 6'd0, "R6 stop gates", int'(gates), 0);
    nr = 0;
    cycles(1500);
    check(nr == 0, "R6 quiet after stop", nr, 0);
  endtask

  task automatic t_same_cycle();
    bit hit;
    step_dly(4, 1'b1);   // delay back to zero
    start_at(300);
    hit = 0;
    while (!hit) begin
      @(posedge clk); #4;
      if (timer == zc - 16'd1) begin #1 lock = 1'b0; hit = 1; end
    end
    cycles(10);
    #2;
    check(nr == 0, "R6 lock drop beats firing", nr, 0);
    check(firing == 1'b0, "R6 same-cycle firing", int'(firing), 0);
    lock = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start_unlocked();
    t_wrap_run();
    t_delay_live();
    t_delay_sat();
    t_lock_loss();
    t_stop();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule